// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recently used page translations and answers, in the same cycle as a lookup is presented, whether the virtual page is held and, if so, which physical page backs it. Every held translation carries a valid flag, read, write and user-access permissions and a dirty flag. The lookup combines the tag search with a permission check that depends on the requester's privilege mode and on whether it reads or writes. A permitted hit returns the physical address: the physical page number followed by the unchanged 12-bit page offset. A denied hit raises a fault and returns no address.

On a miss the block raises a miss flag so that a table walker outside it can fetch the translation and write it back through the refill port. New translations take the slot indicated by a first-in-first-out pointer. A refill whose page is already held rewrites that slot in place. A flush input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After a synchronous active-low reset no slot is valid and the replacement pointer is zero, so every lookup misses.
- R2: The buffer is fully associative with a depth parameter of 32 to 128 (default 64); any slot may hold any virtual page number.
- R3: A lookup that hits a permitted entry returns, in the same cycle, `lk_paddr` = {stored physical page, `lk_ofs`}, with `lk_hit`=1 and `lk_fault`=0.
- R4: A lookup with no valid matching slot gives `lk_miss`=1, `lk_hit`=0, `lk_fault`=0 and `lk_paddr`=0; with `lk_valid`=0 the hit, miss and fault outputs are all 0.
- R5: A read (`lk_write`=0) needs the entry's read permission and a write (`lk_write`=1) needs its write permission; a denied hit gives `lk_fault`=1, `lk_fault_dirty`=0 and `lk_paddr`=0.
- R6: In user mode (`lk_user`=1) a hit on an entry without the user-access permission is denied as in R5; in kernel mode (`lk_user`=0) that permission is not consulted.
- R7: A write hit that passes R5 and R6 on an entry whose dirty flag is clear gives `lk_fault`=1, `lk_fault_dirty`=1 and `lk_paddr`=0.
- R8: A refill of a page not currently held writes slot number P, where P is the replacement pointer, and then P becomes (P+1) mod depth, whatever that slot held.
- R9: A refill of a page already held rewrites that slot's physical page and flags and leaves the pointer unchanged.
- R10: A flush clears every valid flag and sets the pointer to zero in one cycle; a refill in the same cycle is discarded.
- R11: A refill becomes visible to lookups from the next cycle; a lookup in the refill cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_ofs | input | OFS_W | Page offset, passed through to the physical address |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_hit | output | 1 | A valid slot matches the lookup |
| lk_miss | output | 1 | Lookup presented and no valid slot matches |
| lk_fault | output | 1 | Hit denied by permissions or by a clear dirty flag on a write |
| lk_fault_dirty | output | 1 | The fault is only the clear dirty flag on a permitted write |
| lk_paddr | output | PPN_W+OFS_W | Physical address on a permitted hit, else zero |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | VPN_W | Virtual page number of the refill |
| fill_ppn | input | PPN_W | Physical page number of the refill |
| fill_rd | input | 1 | Read permission of the refill |
| fill_wr | input | 1 | Write permission of the refill |
| fill_usr | input | 1 | User-access permission of the refill |
| fill_dirty | input | 1 | Dirty flag of the refill |
| flush | input | 1 | Invalidate all slots and reset the pointer |

## Verification
The bench fills every slot of a 32-deep buffer with all sixteen permission combinations and sweeps each page under both modes and both access types, so a design that swapped the read and write checks, let kernel mode fail on the user flag, or let user mode bypass it would return addresses it must withhold or fault where it must not. Replacement is probed by evicting the oldest slots in order; a pointer that did not wrap, or that advanced on an in-place rewrite, would evict the wrong page or leave a duplicate tag. A flush followed by a full refill cycle exposes a pointer not returned to zero, and a flush racing a refill exposes wrong priority. Lookups in the refill cycle catch a design that forwards the new entry early.

// File: rtl/tlb_pkg.sv
// Shared types for the translation buffer.
// Assumes nothing beyond standard packed-struct support.
package tlb_pkg;

    // Permission and state flags stored with each translation
    typedef struct packed {
        logic rd;     // read permitted
        logic wr;     // write permitted
        logic usr;    // user-mode access permitted
        logic dirty;  // page already marked modified
    } tlb_perm_t;

    // Result of the protection check
    typedef struct packed {
        logic denied;     // permission violation
        logic need_dirty; // permitted write to a clean page
    } tlb_verdict_t;

endpackage

// File: rtl/tlb_victim_ptr.sv
// First-in-first-out replacement pointer.
// Advances by one, wrapping at DEPTH-1, when a new page is allocated.
// Assumes flush and advance are never expected to both take effect; flush wins.
module tlb_victim_ptr #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // Hold or step the pointer; reset and flush return it to slot zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (flush) begin
            ptr <= '0;
        end else if (advance) begin
            if (ptr == LAST) begin
                ptr <= '0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_entry_store.sv
// Slot storage and associative search.
// Holds DEPTH translations; compares every tag in parallel for the lookup
// port and, separately, for the refill port. Assumes no two valid slots
// hold the same tag (the top guarantees this), so match vectors are one-hot
// or zero and OR-reduction yields the selected slot.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  tlb_perm_t        wr_perm,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PPN_W-1:0] look_ppn,
    output tlb_perm_t        look_perm,
    input  logic [VPN_W-1:0] fill_vpn,
    output logic             fill_hit,
    output logic [IDX_W-1:0] fill_idx
);

    logic [DEPTH-1:0] valid_q;
    logic [VPN_W-1:0] tag_q  [DEPTH];
    logic [PPN_W-1:0] ppn_q  [DEPTH];
    tlb_perm_t        perm_q [DEPTH];
    logic [DEPTH-1:0] look_match;
    logic [DEPTH-1:0] fill_match;

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);

        // Valid flag: cleared by reset or flush, set when this slot is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
            end else if (flush) begin
                valid_q[e] <= 1'b0;
            end else if (wr_en && (wr_idx == SLOT)) begin
                valid_q[e] <= 1'b1;
            end
        end

        // Payload: tag, physical page and flags captured on a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[e]  <= '0;
                ppn_q[e]  <= '0;
                perm_q[e] <= '0;
            end else if (wr_en && !flush && (wr_idx == SLOT)) begin
                tag_q[e]  <= wr_vpn;
                ppn_q[e]  <= wr_ppn;
                perm_q[e] <= wr_perm;
            end
        end

        // Per-slot comparators for both ports
        assign look_match[e] = valid_q[e] && (tag_q[e] == look_vpn);
        assign fill_match[e] = valid_q[e] && (tag_q[e] == fill_vpn);
    end

    // Select the payload of the matching slot for the lookup port
    always_comb begin
        look_ppn  = '0;
        look_perm = '0;
        for (int i = 0; i < DEPTH; i++) begin
            look_ppn  = look_ppn  | ({PPN_W{look_match[i]}} & ppn_q[i]);
            look_perm = look_perm | ({$bits(tlb_perm_t){look_match[i]}} & perm_q[i]);
        end
    end

    // Encode the matching slot number for the refill port
    always_comb begin
        fill_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (fill_match[i]) begin
                fill_idx = fill_idx | IDX_W'(i);
            end
        end
    end

    assign look_hit = |look_match;
    assign fill_hit = |fill_match;

endmodule

// File: rtl/tlb_prot_check.sv
// Protection check applied to a hit.
// Read needs rd, write needs wr, user mode additionally needs usr;
// kernel mode ignores usr. A permitted write to a clean page is flagged
// separately so the dirty flag can be set outside the block.
module tlb_prot_check
    import tlb_pkg::*;
(
    input  logic         user_mode,
    input  logic         is_write,
    input  tlb_perm_t    perm,
    output tlb_verdict_t verdict
);

    logic acc_ok;
    logic mode_ok;

    // Access-type and privilege tests combined into the verdict
    always_comb begin
        acc_ok             = is_write ? perm.wr : perm.rd;
        mode_ok            = !user_mode || perm.usr;
        verdict.denied     = !(acc_ok && mode_ok);
        verdict.need_dirty = acc_ok && mode_ok && is_write && !perm.dirty;
    end

endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation buffer, top level.
// Lookup is combinational from lk_* to the result outputs. Refill and
// flush take effect at the next rising edge. A refill whose page is already
// held reuses its slot; otherwise it takes the FIFO victim slot.
// Assumes DEPTH is between 32 and 128.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int OFS_W = 12,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PA_W  = PPN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFS_W-1:0] lk_ofs,
    input  logic             lk_user,
    input  logic             lk_write,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic             lk_fault_dirty,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_usr,
    input  logic             fill_dirty,
    input  logic             flush
);

    logic             slot_hit;
    logic [PPN_W-1:0] slot_ppn;
    tlb_perm_t        slot_perm;
    logic             dup_hit;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] wr_idx;
    logic             alloc_new;
    tlb_perm_t        new_perm;
    tlb_verdict_t     verdict;

    // Pack refill flags and pick the slot the refill writes
    always_comb begin
        new_perm.rd    = fill_rd;
        new_perm.wr    = fill_wr;
        new_perm.usr   = fill_usr;
        new_perm.dirty = fill_dirty;
        wr_idx         = dup_hit ? dup_idx : victim;
        alloc_new      = fill_en && !dup_hit;
    end

    tlb_entry_store #(
        .DEPTH (DEPTH),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (fill_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_ppn    (fill_ppn),
        .wr_perm   (new_perm),
        .look_vpn  (lk_vpn),
        .look_hit  (slot_hit),
        .look_ppn  (slot_ppn),
        .look_perm (slot_perm),
        .fill_vpn  (fill_vpn),
        .fill_hit  (dup_hit),
        .fill_idx  (dup_idx)
    );

    tlb_victim_ptr #(
        .DEPTH (DEPTH)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .advance (alloc_new),
        .ptr     (victim)
    );

    tlb_prot_check u_prot (
        .user_mode (lk_user),
        .is_write  (lk_write),
        .perm      (slot_perm),
        .verdict   (verdict)
    );

    // Form the lookup result from match and protection verdict
    always_comb begin
        lk_hit         = lk_valid && slot_hit;
        lk_miss        = lk_valid && !slot_hit;
        lk_fault       = lk_hit && (verdict.denied || verdict.need_dirty);
        lk_fault_dirty = lk_hit && verdict.need_dirty;
        lk_paddr       = (lk_hit && !lk_fault) ? {slot_ppn, lk_ofs} : '0;
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
// Property checker for tlb_xlate, attached by bind.
// Observes ports only; relates lookup outputs to inputs and to earlier
// refill and flush activity.
module tlb_xlate_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int OFS_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VPN_W-1:0]       lk_vpn,
    input logic [OFS_W-1:0]       lk_ofs,
    input logic                   lk_user,
    input logic                   lk_write,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic                   lk_fault,
    input logic                   lk_fault_dirty,
    input logic [PPN_W+OFS_W-1:0] lk_paddr,
    input logic                   fill_en,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic                   flush
);

    p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss}) == 1);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit && !lk_miss && !lk_fault);

    p_fault_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit && lk_paddr == '0);

    p_dirty_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault_dirty |-> lk_fault && lk_write);

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_fault) |-> lk_paddr[OFS_W-1:0] == lk_ofs);

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_valid || lk_miss));

    p_fill_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> (!lk_valid || lk_vpn != $past(fill_vpn) || lk_hit));

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_vpn         (lk_vpn),
    .lk_ofs         (lk_ofs),
    .lk_user        (lk_user),
    .lk_write       (lk_write),
    .lk_hit         (lk_hit),
    .lk_miss        (lk_miss),
    .lk_fault       (lk_fault),
    .lk_fault_dirty (lk_fault_dirty),
    .lk_paddr       (lk_paddr),
    .fill_en        (fill_en),
    .fill_vpn       (fill_vpn),
    .flush          (flush)
);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
// Bench: 32-deep, 8-bit page numbers. Expected results are derived from
// the requirements using a small slot model kept in the bench.
module tlb_xlate_test;

    localparam int D  = 32;
    localparam int VW = 8;
    localparam int PW = 8;
    localparam int OW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [OW-1:0] lk_ofs = '0;
    logic          lk_user = 1'b0;
    logic          lk_write = 1'b0;
    logic          lk_hit, lk_miss, lk_fault, lk_fault_dirty;
    logic [PW+OW-1:0] lk_paddr;
    logic          fill_en = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic          fill_rd = 1'b0, fill_wr = 1'b0, fill_usr = 1'b0, fill_dirty = 1'b0;
    logic          flush = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of slots
    logic [VW-1:0] m_vpn [D];
    logic [PW-1:0] m_ppn [D];
    logic [3:0]    m_perm[D];  // {dirty, usr, wr, rd}
    bit            m_v   [D];
    int            m_ptr;

    always #2.5 clk = ~clk;

    tlb_xlate #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .OFS_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_ofs(lk_ofs), .lk_user(lk_user), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_fault_dirty(lk_fault_dirty), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_usr(fill_usr),
        .fill_dirty(fill_dirty), .flush(flush));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) m_v[i] = 0;
        m_ptr = 0;
    endtask

    // model refill per R8/R9
    task automatic model_fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [3:0] pm);
        int slot = -1;
        for (int i = 0; i < D; i++) if (m_v[i] && m_vpn[i] == v) slot = i;
        if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % D;
        end
        m_v[slot] = 1; m_vpn[slot] = v; m_ppn[slot] = p; m_perm[slot] = pm;
    endtask

    // drive one refill for one cycle (inputs changed at negedge)
    task automatic do_fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [3:0] pm);
        @(negedge clk);
        fill_en = 1; fill_vpn = v; fill_ppn = p;
        {fill_dirty, fill_usr, fill_wr, fill_rd} = pm;
        @(negedge clk);
        fill_en = 0;
        model_fill(v, p, pm);
    endtask

    // one lookup compared against the model; returns via checks
    task automatic do_look(input logic [VW-1:0] v, input bit usr, input bit wr);
        int slot = -1;
        logic [3:0] pm;
        bit hit, den, dty, flt;
        logic [PW+OW-1:0] pa;
        string req;
        lk_valid = 1; lk_vpn = v; lk_user = usr; lk_write = wr;
        lk_ofs = OW'((v * 37 + usr * 5 + wr * 11) % 4096);
        #1;
        for (int i = 0; i < D; i++) if (m_v[i] && m_vpn[i] == v) slot = i;
        hit = (slot >= 0);
        pm  = hit ? m_perm[slot] : 4'h0;
        den = hit && ((usr && !pm[2]) || (wr ? !pm[1] : !pm[0]));
        dty = hit && !den && wr && !pm[3];
        flt = den || dty;
        pa  = (hit && !flt) ? {m_ppn[slot], lk_ofs} : '0;
        if (!hit) req = "R4";
        else if (usr && !pm[2]) req = "R6";
        else if (den) req = "R5";
        else if (dty) req = "R7";
        else req = "R3";
        chk(req, {8'h0, lk_hit, lk_miss, lk_fault, lk_fault_dirty, lk_paddr},
                 {8'h0, hit, !hit, flt, dty, pa});
        @(negedge clk);
        lk_valid = 0;
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: empty after reset
        for (int v = 0; v < 8; v++) do_look(VW'(v * 31), 0, 0);
        // R4: idle lookup gives quiet outputs
        #1 chk("R4", {lk_hit, lk_miss, lk_fault}, 3'b000);
        // R2: fill every slot, perms cover all 16 combinations (sweep)
        for (int i = 0; i < D; i++) do_fill(VW'(i * 7 + 3), PW'(i ^ 8'hA5), 4'(i));
        for (int i = 0; i < D; i++)
            for (int m = 0; m < 4; m++) do_look(VW'(i * 7 + 3), m[1], m[0]);
        for (int v = 0; v < 16; v++) do_look(VW'(v * 7 + 4), 0, 0);  // R4 misses
        // R8: next new page replaces oldest (slot 0: vpn 3)
        do_fill(8'hF0, 8'h11, 4'hF);
        do_look(8'd3, 0, 0);
        do_look(8'hF0, 1, 1);
        // R9: rewrite vpn 17 (slot 2) in place; pointer stays at 1
        do_fill(8'd17, 8'h77, 4'hF);
        do_look(8'd17, 1, 1);
        do_look(8'd10, 0, 0);     // slot 1 still there
        do_fill(8'hF1, 8'h22, 4'hB);  // takes slot 1
        do_look(8'd10, 0, 0);
        do_look(8'd17, 0, 0);
        do_look(8'hF1, 1, 0);     // R6 user denied
        do_look(8'hF1, 0, 1);     // R6 kernel bypass, write ok
        // R11: lookup in the refill cycle sees old contents
        @(negedge clk);
        fill_en = 1; fill_vpn = 8'hE0; fill_ppn = 8'h5A; {fill_dirty, fill_usr, fill_wr, fill_rd} = 4'hF;
        lk_valid = 1; lk_vpn = 8'hE0; lk_user = 0; lk_write = 0;
        #1 chk("R11", {lk_hit, lk_miss}, 2'b01);
        @(negedge clk);
        fill_en = 0;
        model_fill(8'hE0, 8'h5A, 4'hF);
        #1 chk("R11", {lk_hit, lk_paddr[PW+OW-1:OW]}, {1'b1, 8'h5A});
        lk_valid = 0;
        // R10: flush empties all; pointer back to zero
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
        model_clear();
        for (int i = 0; i < 8; i++) do_look(VW'(i * 7 + 3), 0, 0);
        do_look(8'hF0, 0, 0);
        for (int i = 0; i < D; i++) do_fill(VW'(100 + i), VW'(i), 4'hF);
        do_fill(8'hC8, 8'h33, 4'hF);  // must evict vpn 100 (slot 0)
        do_look(8'd100, 0, 0);
        do_look(8'd101, 0, 0);
        do_look(8'hC8, 0, 1);
        // R10: flush beats same-cycle refill
        @(negedge clk);
        flush = 1; fill_en = 1; fill_vpn = 8'h44; fill_ppn = 8'h01; {fill_dirty, fill_usr, fill_wr, fill_rd} = 4'hF;
        @(negedge clk);
        flush = 0; fill_en = 0;
        model_clear();
        do_look(8'h44, 0, 0);
        do_look(8'hC8, 0, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule